// File: doc/BRIEF.md
# Operand Hazard Interlock and Bypass Selector

This block sits beside the decode stage of an in-order five-stage integer pipeline. Every cycle it takes the two source-register numbers of the instruction being decoded. It compares them against the destination registers held in the execute, memory and writeback pipeline registers. For each operand it returns a select code for the operand multiplexer. The code picks either the register-file read value or a result still travelling down the pipe. When several stages hold a matching write, the youngest one wins.

An instruction may need the result of a load that is still in execute. That value does not exist yet, so it cannot be bypassed. In this case the block freezes fetch and decode for one cycle and turns the execute slot into a bubble. A small two-state machine, FLOW and HELD, makes sure each load-use pair costs exactly one cycle. FLOW is the normal state. A load-use detection in FLOW raises the freeze and moves the machine to HELD. HELD always returns to FLOW on the next edge and masks any stall request while it is active.

A store whose data register is written by the load just ahead of it does not stall. Instead the block flags a late bypass, which the memory stage uses to take the loaded value directly.

Top module: `haz_fwd_unit`

## Requirements
- R1: After reset the machine is in FLOW, so the first load-use pair stalls at once. With no pending writes, every output is zero.
- R2: The select codes are 0 for the register file, 1 for execute, 2 for memory and 3 for writeback. When no stage matches an operand, its code is 0.
- R3: An operand matching an enabled execute-stage destination that is not a load gets code 1, whatever the later stages hold.
- R4: An operand whose nearest enabled match is the memory stage gets code 2.
- R5: An operand whose only enabled match is the writeback stage gets code 3.
- R6: Source register 0 always gets code 0, even when a stage writes register 0.
- R7: A stage whose write enable is low is never a match, even when its register number is equal.
- R8: `freeze_fd` and `bubble_ex` rise in the same cycle, with no registered delay, in either of two cases. The first is a load in execute with its write enable set whose nonzero destination equals `id_rs`. The second is the same load with its destination equal to `id_rt` while `id_store` is low.
- R9: The stall lasts exactly one cycle. In the cycle after a stall (state HELD), no stall is raised even if the inputs still show a load-use pair.
- R10: Suppose a store (`id_store` high) has its `id_rt` equal to the nonzero destination of a load in execute, and no stall is raised that cycle. Then `store_bypass` is 1 and the store causes no stall.
- R11: A load in execute is never chosen as a bypass source (code 1). The operand falls through to the memory, writeback or register-file choice.
- R12: The two operands are resolved independently; each may get a different code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_store | input | 1 | Decode instruction is a store (id_rt is its data) |
| ex_rd | input | AW | Destination register in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | AW | Destination register in writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_rs_sel | output | 2 | Select code for the first operand |
| fwd_rt_sel | output | 2 | Select code for the second operand |
| freeze_fd | output | 1 | Hold fetch and decode this cycle |
| bubble_ex | output | 1 | Insert a no-op into execute this cycle |
| store_bypass | output | 1 | Store data must come from the memory-stage load |

## Verification
The assertions check several properties on every cycle:
- a stall never lasts two cycles in a row;
- register 0 is never bypassed;
- a load in execute is never a bypass source;
- no stall appears without a load in execute;
- a store fed only by the load ahead does not stall.

The exact priority among the three stages can only be shown by the bench's sweep over every combination of a four-register configuration. The same holds for the effect of disabled write enables and for the one-cycle HELD masking when identical load-use inputs persist. That sweep compares each cycle against codes computed from the requirements.

// File: rtl/haz_pkg.sv
package haz_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_WB  = 2'd3
    } opnd_src_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HELD = 1'b1
    } ilk_state_e;

    localparam int NUM_OPND  = 2;
    localparam int NUM_STAGE = 3;
endpackage

// File: rtl/haz_src_pick.sv
module haz_src_pick
    import haz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output opnd_src_e     sel,
    output logic          load_hit
);
    logic [AW-1:0]        stage_rd  [NUM_STAGE];
    logic [NUM_STAGE-1:0] stage_wen;
    logic [NUM_STAGE-1:0] hit;
    logic                 src_live;

    assign stage_rd[0] = ex_rd;
    assign stage_rd[1] = mem_rd;
    assign stage_rd[2] = wb_rd;
    assign stage_wen   = {wb_wen, mem_wen, ex_wen};
    assign src_live    = (src != '0);

    for (genvar s = 0; s < NUM_STAGE; s++) begin : g_cmp
        assign hit[s] = src_live && stage_wen[s] && (stage_rd[s] == src);
    end

    // execute result of a load is not yet available
    assign load_hit = hit[0] && ex_load;

    always_comb begin
        if (hit[0] && !ex_load) begin
            sel = SRC_EX;
        end else if (hit[1]) begin
            sel = SRC_MEM;
        end else if (hit[2]) begin
            sel = SRC_WB;
        end else begin
            sel = SRC_RF;
        end
    end
endmodule

// File: rtl/haz_stall_fsm.sv
module haz_stall_fsm
    import haz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic need_stall,
    output logic stall
);
    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: if (need_stall) state_d = ST_HELD;
            ST_HELD: state_d = ST_FLOW;
            default: state_d = ST_FLOW;
        endcase
    end

    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            ST_FLOW: stall = need_stall;
            ST_HELD: stall = 1'b0;
            default: stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/haz_fwd_unit.sv
module haz_fwd_unit
    import haz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs,
    input  logic [AW-1:0] id_rt,
    input  logic          id_store,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    fwd_rs_sel,
    output logic [1:0]    fwd_rt_sel,
    output logic          freeze_fd,
    output logic          bubble_ex,
    output logic          store_bypass
);
    logic [AW-1:0]       opnd     [NUM_OPND];
    opnd_src_e           opnd_sel [NUM_OPND];
    logic [NUM_OPND-1:0] load_hit;
    logic                need_stall;
    logic                stall;

    assign opnd[0] = id_rs;
    assign opnd[1] = id_rt;

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        haz_src_pick #(.AW(AW)) u_pick (
            .src      (opnd[k]),
            .ex_rd    (ex_rd),
            .ex_wen   (ex_wen),
            .ex_load  (ex_load),
            .mem_rd   (mem_rd),
            .mem_wen  (mem_wen),
            .wb_rd    (wb_rd),
            .wb_wen   (wb_wen),
            .sel      (opnd_sel[k]),
            .load_hit (load_hit[k])
        );
    end

    // store data waits for the memory-stage bypass instead of stalling
    assign need_stall = load_hit[0] || (load_hit[1] && !id_store);

    haz_stall_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_stall (need_stall),
        .stall      (stall)
    );

    assign fwd_rs_sel   = opnd_sel[0];
    assign fwd_rt_sel   = opnd_sel[1];
    assign freeze_fd    = stall;
    assign bubble_ex    = stall;
    assign store_bypass = id_store && load_hit[1] && !stall;
endmodule

// File: rtl/haz_fwd_chk.sv
module haz_fwd_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_rs,
    input logic [AW-1:0] id_rt,
    input logic          id_store,
    input logic [AW-1:0] ex_rd,
    input logic          ex_wen,
    input logic          ex_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_wen,
    input logic [AW-1:0] wb_rd,
    input logic          wb_wen,
    input logic [1:0]    fwd_rs_sel,
    input logic [1:0]    fwd_rt_sel,
    input logic          freeze_fd,
    input logic          bubble_ex,
    input logic          store_bypass
);
    AST_ONE_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_fd |=> !freeze_fd); // R9
    AST_ZERO_RS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0) |-> (fwd_rs_sel == 2'd0)); // R6
    AST_ZERO_RT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rt == '0) |-> (fwd_rt_sel == 2'd0)); // R6
    AST_LOAD_NOT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ex_load |-> (fwd_rs_sel != 2'd1 && fwd_rt_sel != 2'd1)); // R11
    AST_NO_STALL_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> (!freeze_fd && !bubble_ex)); // R8
    AST_STORE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (id_store && ex_load && ex_wen && ex_rd == id_rt && id_rt != '0 && ex_rd != id_rs)
        |-> (!freeze_fd && store_bypass)); // R10
    AST_BYPASS_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        store_bypass |-> (id_store && ex_load)); // R10
endmodule

bind haz_fwd_unit haz_fwd_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_haz_fwd_unit.sv
module tb_haz_fwd_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 2;
    localparam int SWEEP = 1 << (5 * AW + 5);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic          id_store = 1'b0, ex_wen = 1'b0, ex_load = 1'b0;
    logic          mem_wen = 1'b0, wb_wen = 1'b0;
    logic [1:0]    fwd_rs_sel, fwd_rt_sel;
    logic          freeze_fd, bubble_ex, store_bypass;

    int checks = 0;
    int errors = 0;
    bit stalled = 1'b0;

    haz_fwd_unit #(.AW(AW)) dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (rs=%0d rt=%0d st=%0b ex=%0d/%0b/%0b mem=%0d/%0b wb=%0d/%0b)",
                     tag, act, exp, id_rs, id_rt, id_store, ex_rd, ex_wen, ex_load,
                     mem_rd, mem_wen, wb_rd, wb_wen);
        end
    endtask

    function automatic int exp_sel(input logic [AW-1:0] s);
        if (s == '0) return 0;
        if (ex_wen && ex_rd == s && !ex_load) return 1;
        if (mem_wen && mem_rd == s) return 2;
        if (wb_wen && wb_rd == s) return 3;
        return 0;
    endfunction

    function automatic string sel_tag(input logic [AW-1:0] s, input int e);
        if (s == '0) return "R6";
        case (e)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R2";
        endcase
    endfunction

    // drive at negedge, sample 2 time units later, model the HELD state
    task automatic apply(input string tag,
                         input logic [AW-1:0] rs, input logic [AW-1:0] rt, input logic st,
                         input logic [AW-1:0] exr, input logic exw, input logic exl,
                         input logic [AW-1:0] mr, input logic mw,
                         input logic [AW-1:0] wr, input logic ww);
        bit lu_rs, lu_rt, need, e_frz, e_byp;
        int e_rs, e_rt;
        @(negedge clk);
        id_rs = rs; id_rt = rt; id_store = st;
        ex_rd = exr; ex_wen = exw; ex_load = exl;
        mem_rd = mr; mem_wen = mw; wb_rd = wr; wb_wen = ww;
        #2;
        e_rs  = exp_sel(rs);
        e_rt  = exp_sel(rt);
        lu_rs = exl && exw && exr == rs && rs != '0;
        lu_rt = exl && exw && exr == rt && rt != '0;
        need  = lu_rs || (lu_rt && !st);
        e_frz = need && !stalled;
        e_byp = st && lu_rt && !e_frz;
        check({tag, "/", sel_tag(rs, e_rs), " rs_sel"}, int'(fwd_rs_sel), e_rs);
        check({tag, "/", sel_tag(rt, e_rt), " rt_sel"}, int'(fwd_rt_sel), e_rt);
        check({tag, (need && stalled) ? "/R9" : "/R8", " freeze"}, int'(freeze_fd), int'(e_frz));
        check({tag, "/R8 bubble"}, int'(bubble_ex), int'(e_frz));
        check({tag, "/R10 bypass"}, int'(store_bypass), int'(e_byp));
        stalled = e_frz;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle after reset
        check("R1 rs_sel", int'(fwd_rs_sel), 0);
        check("R1 freeze", int'(freeze_fd), 0);
        rst_n = 1'b1;
        // R1: first load-use right after reset stalls
        apply("R1", 2'd1, 2'd0, 1'b0, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0);
        apply("R1", 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0);
        // R7: disabled execute write is skipped, memory chosen
        apply("R7", 2'd1, 2'd2, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 2'd2, 1'b0);
        // R11: store data after load, rt falls through to writeback
        apply("R11", 2'd3, 2'd1, 1'b1, 2'd1, 1'b1, 1'b1, 2'd2, 1'b1, 2'd1, 1'b1);
        // R9: persistent load-use inputs stall once only
        apply("R9", 2'd2, 2'd3, 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0);
        apply("R9", 2'd2, 2'd3, 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0);
        apply("R9", 2'd2, 2'd3, 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 1'b0);
        // R12: rs from execute, rt from writeback in the same cycle
        apply("R12", 2'd1, 2'd3, 1'b0, 2'd1, 1'b1, 1'b0, 2'd2, 1'b1, 2'd3, 1'b1);
        // R6: register 0 written everywhere is still not forwarded
        apply("R6", 2'd0, 2'd0, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 1'b1);
        // exhaustive sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int c = 0; c < SWEEP; c++) begin
            logic [5*AW+4:0] v;
            v = c[5*AW+4:0];
            apply("SWEEP", v[AW-1:0], v[2*AW-1:AW], v[5*AW],
                  v[3*AW-1:2*AW], v[5*AW+1], v[5*AW+2],
                  v[4*AW-1:3*AW], v[5*AW+3],
                  v[5*AW-1:4*AW], v[5*AW+4]);
        end
        finish_run();
    end
endmodule